// File: doc/BRIEF.md
# Byte-Wide Register Port for a 16-bit Timer

This block sits between an 8-bit register bus and a timebase that keeps a 16-bit count and a 16-bit reload limit. Software reaches the 16-bit values one byte at a time. The port makes those two-byte accesses behave as single accesses where that is needed.

A read of the count's upper byte also takes a snapshot of the lower byte. The next lower-byte read returns that snapshot, so software always sees one coherent count even though the counter keeps moving. Writes to the count are not buffered. Each byte write is handed to the timebase at once as a load strobe with a full 16-bit value. The other byte of that value is taken from the live count.

The reload limit is written into a preload register, upper byte first. Writing the upper byte locks the transfer to the shadow copy that the timebase uses. Only the matching lower-byte write releases the lock. The shadow copy then takes the preload value at the next update event from the timebase.

Top module: `timer_reg_port`

## Requirements
- R1: While and after reset, `bus_rdata` is 0, `cnt_load` is 0 and `rld_shadow` equals the parameter `RLD_RST` (all ones by default).
- R2: A read of address 0 (count upper byte) returns, in the following cycle, bits 15:8 of `cnt_live` as sampled at the read edge. It also stores bits 7:0 from that same edge.
- R3: A read of address 1 (count lower byte) that follows an address-0 read returns the stored lower byte, whatever the count has done since. It then releases the snapshot.
- R4: A second address-0 read with no address-1 read in between takes a fresh snapshot. The next address-1 read returns the newer value.
- R5: An address-1 read with no snapshot pending returns bits 7:0 of `cnt_live` at the read edge.
- R6: A write to address 0 or 1 raises `cnt_load` for exactly one cycle, in the cycle after the write. `cnt_load_val` carries the written byte in the addressed half and the live count's other half, as sampled at the write edge.
- R7: Writing address 2 (reload upper byte) and then address 3 (reload lower byte) arms a transfer. At the next `upd_evt`, `rld_shadow` takes the 16-bit preload value. Further events transfer nothing until the port is armed again.
- R8: Between an address-2 write and the following address-3 write, `upd_evt` leaves `rld_shadow` unchanged.
- R9: An address-3 write that is not preceded by an address-2 write does not arm a transfer. A lower-then-upper write order therefore leaves the shadow locked.
- R10: `rld_shadow` changes only in the cycle after an `upd_evt`.
- R11: Reads of addresses 2 and 3 return the upper and lower bytes of the preload register.
- R12: A read of any address of 4 or above returns 0. A write to such an address changes no register and raises no load.
- R13: `bus_rdata` is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | BW | Write byte |
| bus_rdata | output | BW | Read byte, valid the cycle after `bus_rd` |
| cnt_live | input | 2*BW | Running count from the timebase |
| cnt_load | output | 1 | One-cycle count load strobe |
| cnt_load_val | output | 2*BW | Value to load into the count |
| upd_evt | input | 1 | Update event from the timebase |
| rld_shadow | output | 2*BW | Shadow reload limit used by the timebase |

## Verification
The checker watches these properties on every cycle:
- the value and timing of the upper-byte read;
- zero data on idle cycles and on unmapped reads;
- the load strobe following a count write, and the value it carries;
- the shadow changing only after an update event;
- the reset state.

The bench scenarios show the rest:
- the snapshot surviving a running count and being replaced by a repeated upper read;
- the shadow lock holding across events;
- a lower-then-upper write order not counting as a completed update;
- unmapped writes leaving every register as it was.

Long random mixes of these operations are compared against a bench model.

// File: rtl/timer_reg_pkg.sv
package timer_reg_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_HI = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_RLD_HI = 2'd2,
    SEL_RLD_LO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/trp_cnt_rd_latch.sv
module trp_cnt_rd_latch #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hi,
  input  logic          rd_lo,
  input  logic [BW-1:0] live_lo,
  output logic [BW-1:0] rd_lo_data
);
  logic [BW-1:0] snap_q;
  logic          held_q;

  // Upper read takes the snapshot; lower read consumes it.
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      held_q <= 1'b0;
    end else if (rd_hi) begin
      snap_q <= live_lo;
      held_q <= 1'b1;
    end else if (rd_lo) begin
      held_q <= 1'b0;
    end
  end

  assign rd_lo_data = held_q ? snap_q : live_lo;
endmodule

// File: rtl/trp_cnt_wr_path.sv
module trp_cnt_wr_path #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [BW-1:0]   wdata,
  input  logic [2*BW-1:0] live,
  output logic            load,
  output logic [2*BW-1:0] load_val
);
  // Unbuffered: each byte write is forwarded at once and merged with the live half.
  always_ff @(posedge clk) begin
    if (rst) begin
      load     <= 1'b0;
      load_val <= '0;
    end else begin
      load <= wr_hi | wr_lo;
      if (wr_hi)
        load_val <= {wdata, live[BW-1:0]};
      else if (wr_lo)
        load_val <= {live[2*BW-1:BW], wdata};
    end
  end
endmodule

// File: rtl/trp_rld_preload.sv
module trp_rld_preload #(
  parameter int                BW      = 8,
  parameter logic [2*BW-1:0]   RLD_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [BW-1:0]   wdata,
  input  logic            upd_evt,
  output logic [2*BW-1:0] pre,
  output logic [2*BW-1:0] shadow
);
  logic locked_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= RLD_RST;
      shadow   <= RLD_RST;
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      // The transfer uses the state from before this cycle's write.
      if (upd_evt && armed_q && !locked_q) begin
        shadow  <= pre;
        armed_q <= 1'b0;
      end
      if (wr_hi) begin
        pre[2*BW-1:BW] <= wdata;
        locked_q       <= 1'b1;
        armed_q        <= 1'b0;
      end else if (wr_lo) begin
        pre[BW-1:0] <= wdata;
        if (locked_q) begin
          locked_q <= 1'b0;
          armed_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_reg_port.sv
module timer_reg_port
  import timer_reg_pkg::*;
#(
  parameter int              BW      = 8,
  parameter int              ADDR_W  = 3,
  parameter logic [2*BW-1:0] RLD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     bus_rdata,
  input  logic [2*BW-1:0]   cnt_live,
  output logic              cnt_load,
  output logic [2*BW-1:0]   cnt_load_val,
  input  logic              upd_evt,
  output logic [2*BW-1:0]   rld_shadow
);
  localparam int CW = 2 * BW;

  reg_sel_e      sel;
  logic          hit;
  logic          rd_cnt_hi, rd_cnt_lo;
  logic          wr_cnt_hi, wr_cnt_lo, wr_rld_hi, wr_rld_lo;
  logic [BW-1:0] lo_rd_byte;
  logic [CW-1:0] pre_val;

  assign sel = reg_sel_e'(bus_addr[1:0]);
  assign hit = (bus_addr >> 2) == '0;

  assign rd_cnt_hi = bus_rd && hit && sel == SEL_CNT_HI;
  assign rd_cnt_lo = bus_rd && hit && sel == SEL_CNT_LO;
  assign wr_cnt_hi = bus_wr && hit && sel == SEL_CNT_HI;
  assign wr_cnt_lo = bus_wr && hit && sel == SEL_CNT_LO;
  assign wr_rld_hi = bus_wr && hit && sel == SEL_RLD_HI;
  assign wr_rld_lo = bus_wr && hit && sel == SEL_RLD_LO;

  trp_cnt_rd_latch #(.BW(BW)) u_rd_latch (
    .clk        (clk),
    .rst        (rst),
    .rd_hi      (rd_cnt_hi),
    .rd_lo      (rd_cnt_lo),
    .live_lo    (cnt_live[BW-1:0]),
    .rd_lo_data (lo_rd_byte)
  );

  trp_cnt_wr_path #(.BW(BW)) u_wr_path (
    .clk      (clk),
    .rst      (rst),
    .wr_hi    (wr_cnt_hi),
    .wr_lo    (wr_cnt_lo),
    .wdata    (bus_wdata),
    .live     (cnt_live),
    .load     (cnt_load),
    .load_val (cnt_load_val)
  );

  trp_rld_preload #(.BW(BW), .RLD_RST(RLD_RST)) u_preload (
    .clk     (clk),
    .rst     (rst),
    .wr_hi   (wr_rld_hi),
    .wr_lo   (wr_rld_lo),
    .wdata   (bus_wdata),
    .upd_evt (upd_evt),
    .pre     (pre_val),
    .shadow  (rld_shadow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd && hit) begin
      unique case (sel)
        SEL_CNT_HI: bus_rdata <= cnt_live[CW-1:BW];
        SEL_CNT_LO: bus_rdata <= lo_rd_byte;
        SEL_RLD_HI: bus_rdata <= pre_val[CW-1:BW];
        SEL_RLD_LO: bus_rdata <= pre_val[BW-1:0];
        default:    bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
  parameter int              BW      = 8,
  parameter int              ADDR_W  = 3,
  parameter logic [2*BW-1:0] RLD_RST = '1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BW-1:0]     bus_wdata,
  input logic [BW-1:0]     bus_rdata,
  input logic [2*BW-1:0]   cnt_live,
  input logic              cnt_load,
  input logic [2*BW-1:0]   cnt_load_val,
  input logic              upd_evt,
  input logic [2*BW-1:0]   rld_shadow
);
  logic unmapped;
  logic cnt_wr;
  assign unmapped = (bus_addr >> 2) != '0;
  assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1));

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0 && !cnt_load && rld_shadow == RLD_RST));

  a_r2_hi_read_live: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == ADDR_W'(0)) |-> bus_rdata == $past(cnt_live[2*BW-1:BW]));

  a_r6_load_needs_write: assert property (@(posedge clk) disable iff (rst)
    cnt_load |-> $past(cnt_wr));

  a_r6_write_gives_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_load);

  a_r6_lo_write_value: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == ADDR_W'(1)) |->
      cnt_load_val == {$past(cnt_live[2*BW-1:BW]), $past(bus_wdata)});

  a_r10_shadow_after_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(rld_shadow) |-> $past(upd_evt));

  a_r12_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && unmapped) |-> bus_rdata == '0);

  a_r13_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);
endmodule

bind timer_reg_port trp_checker #(.BW(BW), .ADDR_W(ADDR_W), .RLD_RST(RLD_RST)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .cnt_live     (cnt_live),
  .cnt_load     (cnt_load),
  .cnt_load_val (cnt_load_val),
  .upd_evt      (upd_evt),
  .rld_shadow   (rld_shadow)
);

// File: tb/timer_reg_port_bench.sv
module timer_reg_port_bench;
  localparam int BW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [15:0]   live;
  logic          cnt_load;
  logic [15:0]   cnt_load_val;
  logic          upd_evt = 1'b0;
  logic [15:0]   rld_shadow;
  logic          run = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  m_snap;
  logic        m_held;
  logic [15:0] m_pre, m_sh;
  logic        m_lock, m_arm;
  logic [15:0] last_lv;
  logic [7:0]  got_rd;

  always #10 clk = ~clk;

  timer_reg_port #(.BW(BW), .ADDR_W(AW)) u_timer_reg_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(live),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .upd_evt(upd_evt),
    .rld_shadow(rld_shadow)
  );

  // Bench-side counter standing in for the timebase.
  always @(posedge clk) begin
    if (rst) live <= 16'h0F3A;
    else if (cnt_load) live <= cnt_load_val;
    else if (run) live <= live + 16'd1;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string rd_tag(logic [AW-1:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3/R5";
      3'd2, 3'd3: return "R11";
      default: return "R12";
    endcase
  endfunction

  // One bus cycle; called and returns at a falling edge.
  task automatic cyc(bit rd, bit wr, logic [AW-1:0] a, logic [7:0] d, bit evt);
    logic [15:0] lv;
    logic [7:0]  e_rd;
    bit          e_ld;
    logic [15:0] e_val;
    lv = live;
    last_lv = lv;
    e_rd = 8'h00; e_ld = 1'b0; e_val = '0;
    if (rd) begin
      case (a)
        3'd0: begin e_rd = lv[15:8]; m_snap = lv[7:0]; m_held = 1'b1; end
        3'd1: begin e_rd = m_held ? m_snap : lv[7:0]; m_held = 1'b0; end
        3'd2: e_rd = m_pre[15:8];
        3'd3: e_rd = m_pre[7:0];
        default: e_rd = 8'h00;
      endcase
    end
    if (evt && m_arm && !m_lock) begin m_sh = m_pre; m_arm = 1'b0; end
    if (wr) begin
      case (a)
        3'd0: begin e_ld = 1'b1; e_val = {d, lv[7:0]}; end
        3'd1: begin e_ld = 1'b1; e_val = {lv[15:8], d}; end
        3'd2: begin m_pre[15:8] = d; m_lock = 1'b1; m_arm = 1'b0; end
        3'd3: begin m_pre[7:0] = d; if (m_lock) begin m_lock = 1'b0; m_arm = 1'b1; end end
        default: ;
      endcase
    end
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; upd_evt = evt;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; upd_evt = 1'b0;
    got_rd = bus_rdata;
    chk(rd ? rd_tag(a) : "R13", {24'h0, bus_rdata}, {24'h0, e_rd});
    chk("R6 strobe", {31'h0, cnt_load}, {31'h0, e_ld});
    if (e_ld) chk("R6 value", {16'h0, cnt_load_val}, {16'h0, e_val});
    chk("R7 shadow", {16'h0, rld_shadow}, {16'h0, m_sh});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  snap1;
    logic [15:0] sh_keep;
    void'($urandom(32'h5EED_2024));
    m_held = 1'b0; m_snap = '0; m_pre = 16'hFFFF; m_sh = 16'hFFFF;
    m_lock = 1'b0; m_arm = 1'b0;
    repeat (3) @(negedge clk);
    // R1: values while in reset
    chk("R1 rdata", {24'h0, bus_rdata}, 32'h0);
    chk("R1 load", {31'h0, cnt_load}, 32'h0);
    chk("R1 shadow", {16'h0, rld_shadow}, 32'h0000_FFFF);
    rst = 1'b0;
    @(negedge clk);
    run = 1'b1;

    // R2, R3: snapshot survives counting
    cyc(1, 0, 3'd0, 8'h00, 0);
    snap1 = last_lv[7:0];
    repeat (5) cyc(0, 0, 3'd0, 8'h00, 0);
    cyc(1, 0, 3'd1, 8'h00, 0);
    chk("R3 snapshot", {24'h0, got_rd}, {24'h0, snap1});
    // R4: repeated upper read retakes the snapshot
    cyc(1, 0, 3'd0, 8'h00, 0);
    repeat (3) cyc(0, 0, 3'd0, 8'h00, 0);
    cyc(1, 0, 3'd0, 8'h00, 0);
    snap1 = last_lv[7:0];
    repeat (2) cyc(0, 0, 3'd0, 8'h00, 0);
    cyc(1, 0, 3'd1, 8'h00, 0);
    chk("R4 fresh snapshot", {24'h0, got_rd}, {24'h0, snap1});
    // R5: lower read with nothing held
    cyc(1, 0, 3'd1, 8'h00, 0);
    chk("R5 live low", {24'h0, got_rd}, {24'h0, last_lv[7:0]});
    // R6: count writes
    cyc(0, 1, 3'd0, 8'hAB, 0);
    cyc(0, 1, 3'd1, 8'h5C, 0);
    // R7: upper then lower, then event
    cyc(0, 1, 3'd2, 8'h12, 0);
    cyc(0, 1, 3'd3, 8'h34, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R7 transfer", {16'h0, rld_shadow}, 32'h1234);
    // R8: locked while only the upper byte is written
    cyc(0, 1, 3'd2, 8'h56, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R8 locked", {16'h0, rld_shadow}, 32'h1234);
    cyc(0, 1, 3'd3, 8'h78, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R8 released", {16'h0, rld_shadow}, 32'h5678);
    // R9: lower first then upper is not a completed update
    cyc(0, 1, 3'd3, 8'h9A, 0);
    cyc(0, 1, 3'd2, 8'hBC, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R9 wrong order", {16'h0, rld_shadow}, 32'h5678);
    cyc(0, 1, 3'd3, 8'hDE, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R9 completed", {16'h0, rld_shadow}, 32'hBCDE);
    // R10: event with nothing armed
    cyc(0, 1, 3'd3, 8'h11, 0);
    cyc(0, 0, 3'd0, 8'h00, 1);
    chk("R10 no rearm", {16'h0, rld_shadow}, 32'hBCDE);
    // R11: preload readback
    cyc(1, 0, 3'd2, 8'h00, 0);
    chk("R11 hi", {24'h0, got_rd}, 32'hBC);
    cyc(1, 0, 3'd3, 8'h00, 0);
    chk("R11 lo", {24'h0, got_rd}, 32'h11);
    // R12: unmapped accesses
    sh_keep = rld_shadow;
    cyc(0, 1, 3'd5, 8'hEE, 1);
    cyc(0, 1, 3'd6, 8'h77, 0);
    cyc(1, 0, 3'd7, 8'h00, 0);
    chk("R12 unmapped read", {24'h0, got_rd}, 32'h0);
    cyc(1, 0, 3'd2, 8'h00, 0);
    chk("R12 preload hi intact", {24'h0, got_rd}, 32'hBC);
    cyc(1, 0, 3'd3, 8'h00, 0);
    chk("R12 preload lo intact", {24'h0, got_rd}, 32'h11);
    chk("R12 shadow intact", {16'h0, rld_shadow}, {16'h0, sh_keep});

    // Random mix against the bench model
    for (int i = 0; i < 2000; i++) begin
      int unsigned op;
      op = $urandom_range(0, 2);
      cyc(op == 1, op == 2, AW'($urandom_range(0, 7)), 8'($urandom),
          $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule